// File: doc/BRIEF.md
# Reset Source Controller with Clock-Loss Detection

This block merges three reset requests into one active-low system reset and remembers which of them caused the last one. The first request is an active-low external reset pin. The second is the digital output of a supply comparator. The third is a detector that sees the system clock stop. Everything runs on a free-running reference clock that is independent of the monitored system clock. A power-on reset input clears the whole block. The system reset that the block produces never clears the block's own registers.

The external pin, the comparator output and the system clock are each brought into the reference domain through two flops. The clock-loss detector counts reference cycles since the last edge of the system clock. If the count reaches a programmable limit, the detector requests a reset. Once every request has gone away, the reset output is held low for a further programmable number of reference cycles. At the moment the output is released, the flag of every source that was active during the reset is latched.

Software sees two 8-bit registers through a simple write strobe, a one-bit address and a combinational read port. The monitor register holds the supply-monitor enable and the live supply status. The source register holds the supply-source select, the clock-loss detector enable and the cause flags. One bit position in the source register is shared: writing it sets the detector enable, and reading it returns the clock-loss flag.

Top module: `rst_source_ctrl`

## Requirements
- R1: After por_n is released, sys_rst_n stays low for HOLD_CYC reference cycles and then rises. The source register (address 1) then reads 0x00. The monitor register (address 0) reads 0x80 with bit 6 showing the status, because the enable resets to 1 and the select and detector enable reset to 0.
- R2: A low level on ext_rst_n drives sys_rst_n low by the third reference edge after the pin falls. After release, the pin flag reads 1 in bit 0 of the source register. Bit 0 ignores writes.
- R3: sys_rst_n stays low while any request is active. It rises exactly HOLD_CYC+2 reference edges after ext_rst_n returns high: two edges for the synchronizer and HOLD_CYC edges of hold time. The output never falls while no request is active.
- R4: In the monitor register, bit 7 is the read/write supply-monitor enable. Bit 6 reads the synchronized vdd_ok level: 1 above threshold, 0 at or below. Bits 5:0 read 0 and ignore writes.
- R5: A low vdd_ok causes a reset only when the monitor enable (address 0 bit 7) and the supply select (address 1 bit 1, read/write) are both 1. A supply-caused reset sets the supply flag in bit 3 of the source register. Bit 3 ignores writes.
- R6: With the detector enabled, if sys_clk holds one level for TIMEOUT_CYC reference cycles, a reset is requested. After release, the clock-loss flag reads 1 in bit 2 of the source register.
- R7: Writing 1 to source-register bit 2 enables the detector, and writing 0 disables it. Reads of bit 2 return only the flag. While the detector is disabled, a stopped sys_clk causes no reset.
- R8: The detector counter restarts on every synchronized sys_clk edge. A clock whose every phase is shorter than TIMEOUT_CYC reference cycles never causes a reset.
- R9: When several sources are active in one reset, the flag of each of them is set.
- R10: Each release replaces all cause flags. A flag from an earlier reset reads 0 after a reset from a different source. Flags do not change at any other time.
- R11: The system reset does not affect the enable and select bits or the flags. Only por_n clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for all logic |
| por_n | input | 1 | Asynchronous active-low power-on reset of the whole block |
| sys_clk | input | 1 | Monitored system clock |
| ext_rst_n | input | 1 | External active-low reset pin, asynchronous |
| vdd_ok | input | 1 | Supply comparator output, 1 when above threshold |
| reg_wr | input | 1 | Register write strobe, sampled on ref_clk |
| reg_addr | input | 1 | Register select: 0 monitor register, 1 source register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| sys_rst_n | output | 1 | Active-low system reset output |

## Verification
The assertions take for granted that the sys_clk phases that are meant to count as running are at least two reference cycles long. Without that, the synchronizer could miss an edge. They also take for granted that HOLD_CYC and TIMEOUT_CYC are at least 1. The stimulus keeps to these limits. Its running system clock has phases of four or fifteen reference cycles. All pin, supply and register changes are driven on the falling reference edge, so every asynchronous input is stable for a full cycle before it is sampled. Clock loss is produced by freezing sys_clk at one level for well over the timeout and then restarting it.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    localparam int REG_W = 8;

    typedef enum logic {
        ADDR_MON = 1'b0,
        ADDR_SRC = 1'b1
    } reg_addr_e;

    localparam int MON_EN_BIT   = 7;
    localparam int MON_STAT_BIT = 6;
    localparam int SRC_PIN_BIT  = 0;
    localparam int SRC_SEL_BIT  = 1;
    localparam int SRC_CLK_BIT  = 2;
    localparam int SRC_SUP_BIT  = 3;

    typedef struct packed {
        logic sup;
        logic clk;
        logic pin;
    } cause_t;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) stage_q[g] <= RESET_VAL;
                    else         stage_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) stage_q[g] <= RESET_VAL;
                    else         stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rstc_clk_monitor.sv
module rstc_clk_monitor #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic sys_clk_s,
    input  logic en_i,
    output logic timeout_o
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } mon_state_t;

    mon_state_t st_d, st_q;
    logic       edge_seen;

    always_comb begin
        st_d      = st_q;
        edge_seen = sys_clk_s ^ st_q.prev;
        st_d.prev = sys_clk_s;
        if (!en_i || edge_seen) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign timeout_o = (st_q.cnt == LIMIT);

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!arst_n)
        !en_i |=> !timeout_o);

    assert_edge_restarts_R8: assert property (@(posedge clk) disable iff (!arst_n)
        (sys_clk_s != st_q.prev) |=> !timeout_o);
endmodule

// File: rtl/rstc_sequencer.sv
module rstc_sequencer
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic   clk,
    input  logic   arst_n,
    input  cause_t req_i,
    output logic   rst_n_o,
    output logic   latch_o,
    output cause_t cause_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

    typedef struct packed {
        logic          rst_n;
        logic [HW-1:0] cnt;
        cause_t        pending;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       any_req;

    always_comb begin
        st_d    = st_q;
        any_req = |req_i;
        latch_o = 1'b0;
        if (any_req) begin
            st_d.rst_n   = 1'b0;
            st_d.cnt     = '0;
            st_d.pending = cause_t'(st_q.pending | req_i);
        end else if (!st_q.rst_n) begin
            if (st_q.cnt == LAST) begin
                st_d.rst_n   = 1'b1;
                st_d.cnt     = '0;
                st_d.pending = '0;
                latch_o      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.rst_n   <= 1'b0;
            st_q.cnt     <= '0;
            st_q.pending <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_n_o = st_q.rst_n;
    assign cause_o = st_q.pending;

    assert_req_holds_reset_R3: assert property (@(posedge clk) disable iff (!arst_n)
        (|req_i) |=> !rst_n_o);

    assert_no_spurious_reset_R3: assert property (@(posedge clk) disable iff (!arst_n)
        (rst_n_o && !(|req_i)) |=> rst_n_o);
endmodule

// File: rtl/rstc_regs.sv
module rstc_regs
    import rstc_pkg::*;
(
    input  logic             clk,
    input  logic             arst_n,
    input  logic             wr_i,
    input  logic             addr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             vdd_s_i,
    input  logic             latch_i,
    input  cause_t           cause_i,
    output logic             mon_en_o,
    output logic             sup_sel_o,
    output logic             clk_en_o,
    output logic [REG_W-1:0] rdata_o
);
    typedef struct packed {
        logic   mon_en;
        logic   sup_sel;
        logic   clk_en;
        cause_t flags;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i && addr_i == ADDR_MON) begin
            st_d.mon_en = wdata_i[MON_EN_BIT];
        end
        if (wr_i && addr_i == ADDR_SRC) begin
            st_d.sup_sel = wdata_i[SRC_SEL_BIT];
            st_d.clk_en  = wdata_i[SRC_CLK_BIT];
        end
        if (latch_i) begin
            st_d.flags = cause_i;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.mon_en  <= 1'b1;
            st_q.sup_sel <= 1'b0;
            st_q.clk_en  <= 1'b0;
            st_q.flags   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_MON) begin
            rdata_o[MON_EN_BIT]   = st_q.mon_en;
            rdata_o[MON_STAT_BIT] = vdd_s_i;
        end else begin
            rdata_o[SRC_PIN_BIT] = st_q.flags.pin;
            rdata_o[SRC_SEL_BIT] = st_q.sup_sel;
            rdata_o[SRC_CLK_BIT] = st_q.flags.clk;
            rdata_o[SRC_SUP_BIT] = st_q.flags.sup;
        end
    end

    assign mon_en_o  = st_q.mon_en;
    assign sup_sel_o = st_q.sup_sel;
    assign clk_en_o  = st_q.clk_en;

    assert_flags_only_on_release_R10: assert property (@(posedge clk) disable iff (!arst_n)
        !latch_i |=> $stable(st_q.flags));

    assert_enable_needs_write_R4: assert property (@(posedge clk) disable iff (!arst_n)
        !(wr_i && addr_i == ADDR_MON) |=> $stable(st_q.mon_en));
endmodule

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl
    import rstc_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1000,
    parameter int HOLD_CYC = 16
) (
    input  logic             ref_clk,
    input  logic             por_n,
    input  logic             sys_clk,
    input  logic             ext_rst_n,
    input  logic             vdd_ok,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             sys_rst_n
);
    logic [2:0] async_in;
    logic [2:0] sync_out;
    logic       sys_clk_s, vdd_s, pin_s;
    logic       mon_en, sup_sel, clk_en;
    logic       timeout, latch;
    cause_t     req, cause;

    assign async_in = {sys_clk, vdd_ok, ext_rst_n};

    rstc_sync #(.WIDTH(3), .STAGES(2), .RESET_VAL(3'b011)) u_sync (
        .clk(ref_clk), .arst_n(por_n), .d_i(async_in), .q_o(sync_out)
    );

    assign sys_clk_s = sync_out[2];
    assign vdd_s     = sync_out[1];
    assign pin_s     = sync_out[0];

    rstc_clk_monitor #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_mon (
        .clk(ref_clk), .arst_n(por_n), .sys_clk_s(sys_clk_s),
        .en_i(clk_en), .timeout_o(timeout)
    );

    always_comb begin
        req     = '0;
        req.pin = !pin_s;
        req.sup = mon_en && sup_sel && !vdd_s;
        req.clk = timeout;
    end

    rstc_sequencer #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk(ref_clk), .arst_n(por_n), .req_i(req),
        .rst_n_o(sys_rst_n), .latch_o(latch), .cause_o(cause)
    );

    rstc_regs u_regs (
        .clk(ref_clk), .arst_n(por_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .vdd_s_i(vdd_s), .latch_i(latch), .cause_i(cause),
        .mon_en_o(mon_en), .sup_sel_o(sup_sel), .clk_en_o(clk_en),
        .rdata_o(reg_rdata)
    );

    assert_gated_supply_R5: assert property (@(posedge ref_clk) disable iff (!por_n)
        (sys_rst_n && pin_s && !timeout && !(mon_en && sup_sel)) |=> sys_rst_n);
endmodule

// File: tb/rst_source_ctrl_test.sv
module rst_source_ctrl_test;
    localparam int REF_PERIOD = 10;
    localparam int TIMEOUT = 20;
    localparam int HOLD = 8;
    localparam int NVEC = 7;

    // {addr, write data, expected read data}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 8'h3F, 8'h40},
        {1'b0, 8'h80, 8'hC0},
        {1'b1, 8'h02, 8'h02},
        {1'b1, 8'hFB, 8'h02},
        {1'b1, 8'h00, 8'h00},
        {1'b1, 8'h04, 8'h00},
        {1'b1, 8'h00, 8'h00}
    };

    logic       ref_clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_clk = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       vdd_ok = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sys_rst_n;

    int  checks = 0;
    int  fails = 0;
    bit  done = 1'b0;
    bit  sys_run = 1'b1;
    int  sys_half = 40;
    int  low_seen = 0;
    bit  watch_low = 1'b0;

    rst_source_ctrl #(.TIMEOUT_CYC(TIMEOUT), .HOLD_CYC(HOLD)) uut (
        .ref_clk(ref_clk), .por_n(por_n), .sys_clk(sys_clk), .ext_rst_n(ext_rst_n),
        .vdd_ok(vdd_ok), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sys_rst_n(sys_rst_n)
    );

    always #(REF_PERIOD/2) ref_clk = ~ref_clk;

    always begin
        if (sys_run) begin
            #(sys_half);
            sys_clk = ~sys_clk;
        end else begin
            #(REF_PERIOD);
        end
    end

    always @(negedge ref_clk) if (watch_low && !sys_rst_n) low_seen++;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge ref_clk);
        #1;
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        @(negedge ref_clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge ref_clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic a, input logic [7:0] exp);
        @(negedge ref_clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        int n;
        // R1: power-on
        cycles(3);
        @(negedge ref_clk) por_n = 1'b1;
        #1 check("R1 reset held after por", sys_rst_n, 0);
        cycles(HOLD + 4);
        check("R1 reset released", sys_rst_n, 1);
        read_check("R1 source reg reset", 1'b1, 8'h00);
        read_check("R1 monitor reg reset", 1'b0, 8'hC0);

        // R4 R7: register table
        for (int i = 0; i < NVEC; i++) begin
            write_reg(VEC[i][16], VEC[i][15:8]);
            read_check($sformatf("R4/R7 vector %0d", i), VEC[i][16], VEC[i][7:0]);
        end

        // R4 R5: status low, enabled but not selected
        @(negedge ref_clk) vdd_ok = 1'b0;
        cycles(4);
        read_check("R4 status low", 1'b0, 8'h80);
        check("R5 no reset without select", sys_rst_n, 1);
        write_reg(1'b1, 8'h02);
        cycles(4);
        check("R5 supply reset asserted", sys_rst_n, 0);
        @(negedge ref_clk) vdd_ok = 1'b1;
        cycles(HOLD + 6);
        check("R5 supply reset released", sys_rst_n, 1);
        read_check("R5 R11 supply flag and select kept", 1'b1, 8'h0A);
        // R5: selected but monitor disabled
        write_reg(1'b0, 8'h00);
        @(negedge ref_clk) vdd_ok = 1'b0;
        cycles(10);
        check("R5 no reset when monitor disabled", sys_rst_n, 1);
        @(negedge ref_clk) vdd_ok = 1'b1;
        cycles(4);
        write_reg(1'b0, 8'h80);
        write_reg(1'b1, 8'h00);

        // R2 R3 R10: pin reset
        @(negedge ref_clk) ext_rst_n = 1'b0;
        cycles(3);
        check("R2 pin reset asserted", sys_rst_n, 0);
        cycles(4);
        @(negedge ref_clk) ext_rst_n = 1'b1;
        n = 0;
        while (!sys_rst_n && n < 100) begin
            @(posedge ref_clk);
            #1;
            n++;
        end
        check("R3 release edge count", n, HOLD + 2);
        read_check("R2 R10 pin flag only", 1'b1, 8'h01);
        write_reg(1'b1, 8'h09);
        read_check("R2 flags ignore writes", 1'b1, 8'h01);

        // R6 R10: clock loss
        write_reg(1'b1, 8'h04);
        sys_run = 1'b0;
        cycles(TIMEOUT + 10);
        check("R6 clock-loss reset asserted", sys_rst_n, 0);
        sys_run = 1'b1;
        cycles(40);
        check("R6 clock-loss reset released", sys_rst_n, 1);
        read_check("R6 R10 clock-loss flag only", 1'b1, 8'h04);

        // R8: slow clock with short phases
        sys_half = 15 * REF_PERIOD;
        cycles(10);
        low_seen = 0; watch_low = 1'b1;
        cycles(200);
        watch_low = 1'b0;
        check("R8 slow clock no reset", low_seen, 0);
        sys_half = 40;
        cycles(20);

        // R7: disabled detector ignores stopped clock
        write_reg(1'b1, 8'h00);
        low_seen = 0; watch_low = 1'b1;
        sys_run = 1'b0;
        cycles(TIMEOUT * 3);
        sys_run = 1'b1;
        cycles(20);
        watch_low = 1'b0;
        check("R7 disabled detector no reset", low_seen, 0);
        read_check("R7 flag unchanged", 1'b1, 8'h04);

        // R9: two sources together
        write_reg(1'b1, 8'h02);
        @(negedge ref_clk);
        ext_rst_n = 1'b0; vdd_ok = 1'b0;
        cycles(5);
        check("R9 combined reset asserted", sys_rst_n, 0);
        @(negedge ref_clk);
        ext_rst_n = 1'b1; vdd_ok = 1'b1;
        cycles(HOLD + 10);
        check("R9 combined reset released", sys_rst_n, 1);
        read_check("R9 both flags", 1'b1, 8'h0B);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(REF_PERIOD * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule